// File: doc/BRIEF.md
# Sliding-Window Address Generator

This block produces a stream of memory addresses for one address dimension, one address per enabled clock cycle. Within a window the address starts at a floor value and moves by a signed stride until either a per-window address count runs out or the next step would carry the address past the window's bound. At the end of each window, the floor and the bound move by their own signed strides, and the next window starts again at the new floor. A scan window can therefore slide across memory without any help from software between windows.

The floor, the bound and the address are each held by an instance of one common stepper unit. Each unit holds a value and a step counter. It adds a signed stride when told to advance, and it flags its last step when the counter reaches its maximum or when the next value would cross its bound. The two bound-holding units (the floor slider and the bound slider) have their own stop values and share a window count. When either of them is on its last window, the scan finishes at the end of that window. The block then reports done and stays idle until it is loaded again.

A pulse on the load input captures the full configuration and starts a scan. While the scan runs, every cycle with the enable high presents one valid address.

Top module: `slide_addr_gen`

## Requirements
- R1: After a load, the first valid address is the initial floor. Each following enabled cycle inside a window presents the previous address plus the address stride, taken as 16-bit two's complement.
- R2: While the enable is low the address does not advance and the valid output is low. The address output holds its value.
- R3: A window contains at most `addr_max_i` addresses, with a value of 0 treated as 1. The window-end output is high together with the last valid address of the window.
- R4: The window also ends on an address whose successor would cross the current bound. For a positive stride, crossing means the successor is above the bound. For a negative stride, it means the successor is below the bound. A zero stride never crosses. No valid address other than the first of a window lies beyond the bound.
- R5: When a window ends and neither slider is on its last window, the floor advances by the floor stride and the bound advances by the bound stride. The next valid address is the new floor.
- R6: A slider is on its last window when its window count reaches `win_max_i` (0 treated as 1) or when its next value would cross its own stop value, using the sign rule of R4. The window that ends while a slider is on its last window is the final one. From the following cycle, done is high, valid stays low and the address holds until the next load.
- R7: After reset, done is high, valid and window-end are low, and the address output is 0.
- R8: A load restarts the scan from the new configuration at any time, including in the middle of a scan or after done. Valid is low in the load cycle.
- R9: Crossing is judged on the true sum, not the 16-bit wrapped one. A positive step past 0xFFFF, or a negative step below 0, counts as crossing the bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture configuration and start a scan |
| en_i | input | 1 | Produce one address this cycle |
| base_init_i | input | 16 | Initial floor of the first window |
| base_step_i | input | 16 | Signed floor stride per window |
| base_stop_i | input | 16 | Stop value for the floor slider |
| lim_init_i | input | 16 | Initial bound of the first window |
| lim_step_i | input | 16 | Signed bound stride per window |
| lim_stop_i | input | 16 | Stop value for the bound slider |
| addr_step_i | input | 16 | Signed address stride within a window |
| addr_max_i | input | 16 | Maximum addresses per window |
| win_max_i | input | 16 | Maximum number of windows |
| addr_o | output | 16 | Current address |
| addr_vld_o | output | 1 | Address is valid this cycle |
| win_end_o | output | 1 | Last address of the current window |
| done_o | output | 1 | Scan finished or not started |

## Verification
The bench aims at the points where the window ends. A design that tested the bound on the current address instead of its successor would emit one address beyond the bound or stop one early. A design that ignored the stride sign would never end a downward scan at its floor. A design that compared wrapped 16-bit sums would run through 0xFFFF and back to low memory. Slider exhaustion by count and by stop value, zero strides, enable gaps and reloads in the middle of a scan are also driven; an error in any of these shows up as a wrong address, a window of the wrong length, or done asserted in the wrong cycle.

// File: rtl/sag_pkg.sv
// Shared definitions for the sliding-window address generator.
// Assumes: default widths are used unless a module overrides them.
package sag_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int CNT_W_DEF  = 16;

    // Action chosen by the controller for the current cycle.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ADV    = 2'd1,
        ACT_SLIDE  = 2'd2,
        ACT_FINISH = 2'd3
    } sag_act_e;
endpackage

// File: rtl/sag_stepper.sv
// Common stepper unit: a value register that adds a signed stride on each
// advance, plus a step counter. last_o flags that the current value is the
// final one, either because the count is used up or because the next value
// would cross the bound. The bound test uses the true sum, not the wrapped one.
// Assumes: init_i has priority over adv_i; adv_i is only raised when last_o is low.
module sag_stepper #(
    parameter int AW = sag_pkg::ADDR_W_DEF,
    parameter int CW = sag_pkg::CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic [AW-1:0] init_val_i,
    input  logic          adv_i,
    input  logic [AW-1:0] stride_i,
    input  logic [AW-1:0] bound_i,
    input  logic [CW-1:0] max_cnt_i,
    output logic [AW-1:0] val_o,
    output logic [AW-1:0] nxt_o,
    output logic          last_o
);
    localparam int EW = AW + 2;

    logic [AW-1:0]        val_q;
    logic [CW-1:0]        cnt_q;
    logic signed [EW-1:0] sum_full;
    logic signed [EW-1:0] bound_ext;
    logic                 crosses;
    logic                 count_out;

    // Full-precision successor and bound, so that wrap-around is seen as crossing.
    always_comb begin
        sum_full  = $signed({2'b00, val_q}) + $signed({{2{stride_i[AW-1]}}, stride_i});
        bound_ext = $signed({2'b00, bound_i});
    end

    // Sign-aware crossing test: ceiling for positive strides, floor for negative ones.
    always_comb begin
        if (stride_i[AW-1])
            crosses = (sum_full < bound_ext);
        else if (stride_i != '0)
            crosses = (sum_full > bound_ext);
        else
            crosses = 1'b0;
    end

    // Count limit; a maximum of zero behaves as one.
    always_comb count_out = ({1'b0, cnt_q} + 1'b1) >= {1'b0, max_cnt_i};

    assign val_o  = val_q;
    assign nxt_o  = sum_full[AW-1:0];
    assign last_o = count_out | crosses;

    // Value and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            cnt_q <= '0;
        end else if (init_i) begin
            val_q <= init_val_i;
            cnt_q <= '0;
        end else if (adv_i) begin
            val_q <= sum_full[AW-1:0];
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the unit is never advanced beyond its final value.
    p_no_step_past_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !init_i) |-> !last_o);

    // R1: an advance moves the value by exactly the stride (modulo 2^AW).
    p_advance_by_stride_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !init_i) |=> (val_o == AW'($past(val_o) + $past(stride_i))));

    // R2: without init or advance the value holds.
    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !init_i) |=> $stable(val_o));
endmodule

// File: rtl/sag_ctrl.sv
// Scan controller: tracks whether a scan is running and picks the action of
// each cycle: hold, advance the address, slide the window, or finish.
// Assumes: addr_last_i and slide_end_i come from the stepper units and
// reflect the current values.
module sag_ctrl (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              en_i,
    input  logic              addr_last_i,
    input  logic              slide_end_i,
    output sag_pkg::sag_act_e act_o,
    output logic              run_o,
    output logic              vld_o
);
    import sag_pkg::*;

    logic run_q;

    // A valid address is presented only while running and enabled, and never in a load cycle.
    always_comb vld_o = run_q & en_i & ~load_i;

    // Action decode for the current cycle.
    always_comb begin
        if (!vld_o)
            act_o = ACT_HOLD;
        else if (!addr_last_i)
            act_o = ACT_ADV;
        else if (slide_end_i)
            act_o = ACT_FINISH;
        else
            act_o = ACT_SLIDE;
    end

    // Run flag: set by load, cleared after the final address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (load_i)
            run_q <= 1'b1;
        else if (act_o == ACT_FINISH)
            run_q <= 1'b0;
    end

    assign run_o = run_q;

    // R8: a load always leaves the block running.
    p_load_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> run_o);

    // R6: running stops only after the last address of a final window.
    p_halt_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(run_q)) |->
            $past(en_i && addr_last_i && slide_end_i && !load_i));
endmodule

// File: rtl/slide_addr_gen.sv
// Sliding-window address generator for one dimension. Three copies of the
// stepper unit hold the floor, the bound and the address. The address scans
// from the floor toward the bound; at each window end the floor and the bound
// slide by their own strides until a slider runs out.
// Assumes: configuration inputs are sampled only in the load cycle.
module slide_addr_gen #(
    parameter int AW = sag_pkg::ADDR_W_DEF,
    parameter int CW = sag_pkg::CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          en_i,
    input  logic [AW-1:0] base_init_i,
    input  logic [AW-1:0] base_step_i,
    input  logic [AW-1:0] base_stop_i,
    input  logic [AW-1:0] lim_init_i,
    input  logic [AW-1:0] lim_step_i,
    input  logic [AW-1:0] lim_stop_i,
    input  logic [AW-1:0] addr_step_i,
    input  logic [CW-1:0] addr_max_i,
    input  logic [CW-1:0] win_max_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_vld_o,
    output logic          win_end_o,
    output logic          done_o
);
    import sag_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base_step;
        logic [AW-1:0] base_stop;
        logic [AW-1:0] lim_step;
        logic [AW-1:0] lim_stop;
        logic [AW-1:0] addr_step;
        logic [CW-1:0] addr_max;
        logic [CW-1:0] win_max;
    } cfg_t;

    cfg_t          cfg_q;
    sag_act_e      act;
    logic          run;
    logic          vld;
    logic          slide;
    logic          first_q;
    logic [AW-1:0] base_val, base_nxt, lim_val, lim_nxt, addr_val, addr_nxt;
    logic          base_last, lim_last, addr_last;
    logic [AW-1:0] addr_seed;

    // Configuration capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load_i)
            cfg_q <= '{base_step: base_step_i, base_stop: base_stop_i,
                       lim_step:  lim_step_i,  lim_stop:  lim_stop_i,
                       addr_step: addr_step_i, addr_max:  addr_max_i,
                       win_max:   win_max_i};
    end

    sag_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .en_i        (en_i),
        .addr_last_i (addr_last),
        .slide_end_i (base_last | lim_last),
        .act_o       (act),
        .run_o       (run),
        .vld_o       (vld)
    );

    assign slide = (act == ACT_SLIDE);

    // Floor slider.
    sag_stepper #(.AW(AW), .CW(CW)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (load_i),
        .init_val_i (base_init_i),
        .adv_i      (slide),
        .stride_i   (cfg_q.base_step),
        .bound_i    (cfg_q.base_stop),
        .max_cnt_i  (cfg_q.win_max),
        .val_o      (base_val),
        .nxt_o      (base_nxt),
        .last_o     (base_last)
    );

    // Bound slider.
    sag_stepper #(.AW(AW), .CW(CW)) u_lim (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (load_i),
        .init_val_i (lim_init_i),
        .adv_i      (slide),
        .stride_i   (cfg_q.lim_step),
        .bound_i    (cfg_q.lim_stop),
        .max_cnt_i  (cfg_q.win_max),
        .val_o      (lim_val),
        .nxt_o      (lim_nxt),
        .last_o     (lim_last)
    );

    // Address restarts at the initial floor on load, at the slid floor otherwise.
    always_comb addr_seed = load_i ? base_init_i : base_nxt;

    // Address stepper, bounded by the live bound slider value.
    sag_stepper #(.AW(AW), .CW(CW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (load_i | slide),
        .init_val_i (addr_seed),
        .adv_i      (act == ACT_ADV),
        .stride_i   (cfg_q.addr_step),
        .bound_i    (lim_val),
        .max_cnt_i  (cfg_q.addr_max),
        .val_o      (addr_val),
        .nxt_o      (addr_nxt),
        .last_o     (addr_last)
    );

    // Marks the first address of a window (may lie beyond the bound).
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b1;
        else if (load_i || slide)
            first_q <= 1'b1;
        else if (act == ACT_ADV)
            first_q <= 1'b0;
    end

    assign addr_o     = addr_val;
    assign addr_vld_o = vld;
    assign win_end_o  = vld & addr_last;
    assign done_o     = ~run;

    // R4: with a positive stride, later addresses stay at or below the bound.
    p_ceiling_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !first_q && !cfg_q.addr_step[AW-1] && !load_i) |-> (addr_val <= lim_val));

    // R4: with a negative stride, later addresses stay at or above the bound.
    p_floor_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !first_q && cfg_q.addr_step[AW-1] && !load_i) |-> (addr_val >= lim_val));

    // R5: after a slide, the address restarts at the new floor.
    p_restart_at_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(slide) && !$past(load_i)) |-> (addr_val == base_val));

    // R5: after a slide, the bound has moved by its stride.
    p_bound_slid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(slide) && !$past(load_i)) |-> (lim_val == $past(lim_nxt)));

    // R4: the address never advances into a crossing successor.
    p_no_cross_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ADV) |=> (addr_val == $past(addr_nxt)));
endmodule

// File: tb/tb_slide_addr_gen.sv
// Bench: a behavioural reference model of the scan, compared with the
// outputs on every clock.
module tb_slide_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i, en_i;
    logic [15:0] base_init_i, base_step_i, base_stop_i;
    logic [15:0] lim_init_i, lim_step_i, lim_stop_i;
    logic [15:0] addr_step_i, addr_max_i, win_max_i;
    logic [15:0] addr_o;
    logic        addr_vld_o, win_end_o, done_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    int m_run, m_addr, m_base, m_lim, m_acnt, m_wcnt;
    int c_bstep, c_bstop, c_lstep, c_lstop, c_astep, c_amax, c_wmax;

    always #4 clk = ~clk;

    slide_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .en_i(en_i),
        .base_init_i(base_init_i), .base_step_i(base_step_i), .base_stop_i(base_stop_i),
        .lim_init_i(lim_init_i), .lim_step_i(lim_step_i), .lim_stop_i(lim_stop_i),
        .addr_step_i(addr_step_i), .addr_max_i(addr_max_i), .win_max_i(win_max_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o), .win_end_o(win_end_o), .done_o(done_o)
    );

    function automatic int sx(int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    // R4 and R9: sign-aware crossing on the true sum.
    function automatic int crosses(int v, int s, int b);
        int n;
        n = v + sx(s);
        if (sx(s) > 0) return (n > b) ? 1 : 0;
        if (sx(s) < 0) return (n < b) ? 1 : 0;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check, then advance the model.
    task automatic cyc(input logic ld, input logic en, input string tag);
        int vld, alast, blast, llast;
        @(negedge clk);
        load_i = ld;
        en_i   = en;
        #2;
        vld   = (m_run != 0 && en && !ld) ? 1 : 0;
        alast = ((m_acnt + 1 >= c_amax) || crosses(m_addr, c_astep, m_lim)) ? 1 : 0;
        check({tag, " addr"}, addr_o, m_addr);
        check("R2 valid", addr_vld_o, vld);
        check("R3 window end", win_end_o, vld & alast);
        check("R6 done", done_o, (m_run != 0) ? 0 : 1);
        if (ld) begin
            m_run = 1; m_addr = base_init_i; m_base = base_init_i; m_lim = lim_init_i;
            m_acnt = 0; m_wcnt = 0;
            c_bstep = base_step_i; c_bstop = base_stop_i;
            c_lstep = lim_step_i;  c_lstop = lim_stop_i;
            c_astep = addr_step_i; c_amax = addr_max_i; c_wmax = win_max_i;
        end else if (vld != 0) begin
            if (!alast) begin
                m_addr = (m_addr + sx(c_astep)) & 16'hFFFF;
                m_acnt++;
            end else begin
                blast = ((m_wcnt + 1 >= c_wmax) || crosses(m_base, c_bstep, c_bstop)) ? 1 : 0;
                llast = ((m_wcnt + 1 >= c_wmax) || crosses(m_lim, c_lstep, c_lstop)) ? 1 : 0;
                if (blast || llast) begin
                    m_run = 0;
                end else begin
                    m_base = (m_base + sx(c_bstep)) & 16'hFFFF;
                    m_lim  = (m_lim + sx(c_lstep)) & 16'hFFFF;
                    m_addr = m_base;
                    m_acnt = 0;
                    m_wcnt++;
                end
            end
        end
    endtask

    task automatic setcfg(int b0, int bs, int bst, int l0, int ls, int lst,
                          int as, int am, int wm);
        base_init_i = 16'(b0); base_step_i = 16'(bs); base_stop_i = 16'(bst);
        lim_init_i  = 16'(l0); lim_step_i  = 16'(ls); lim_stop_i  = 16'(lst);
        addr_step_i = 16'(as); addr_max_i  = 16'(am); win_max_i   = 16'(wm);
    endtask

    // Run n cycles; gap=1 drops the enable every third cycle.
    task automatic run(int n, int gap, string tag);
        for (int i = 0; i < n; i++)
            cyc(1'b0, (gap != 0 && (i % 3) == 2) ? 1'b0 : 1'b1, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; en_i = 1'b0;
        setcfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
        m_run = 0; m_addr = 0; m_base = 0; m_lim = 0; m_acnt = 0; m_wcnt = 0;
        c_bstep = 0; c_bstop = 0; c_lstep = 0; c_lstop = 0; c_astep = 0; c_amax = 0; c_wmax = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state.
        #2;
        check("R7 reset addr", addr_o, 0);
        check("R7 reset valid", addr_vld_o, 0);
        check("R7 reset window end", win_end_o, 0);
        check("R7 reset done", done_o, 1);

        // R1, R3, R5: upward stride, count-limited windows, sliding floor and bound.
        setcfg(16'h0100, 16'h0010, 16'h0200, 16'h0140, 16'h0010, 16'h0300, 4, 5, 3);
        cyc(1'b1, 1'b1, "R8 load");
        run(22, 0, "R1 R5 slide");

        // R4, R2: positive bound crossing with enable gaps.
        setcfg(16'h0010, 16'h0008, 16'h0100, 16'h001C, 16'h0008, 16'h0200, 3, 100, 4);
        cyc(1'b1, 1'b0, "R8 load");
        run(40, 1, "R4 R2 ceiling");

        // R4: negative strides, bound acting as floor.
        setcfg(16'h0200, 16'hFFE0, 16'h0000, 16'h01F0, 16'hFFE0, 16'h0000, 16'hFFFB, 50, 4);
        cyc(1'b1, 1'b1, "R8 load");
        run(20, 0, "R4 floor");

        // R3, R4: zero stride, windows end by count only; addr_max 0 acts as 1 in second run.
        setcfg(16'h0050, 16'h0001, 16'hFFFF, 16'h0050, 16'h0001, 16'hFFFF, 0, 3, 2);
        cyc(1'b1, 1'b1, "R8 load");
        run(9, 0, "R3 zero stride");
        setcfg(16'h0020, 16'h0002, 16'h0FFF, 16'h0040, 16'h0002, 16'h0FFF, 1, 0, 3);
        cyc(1'b1, 1'b1, "R8 load");
        run(6, 0, "R3 max zero");

        // R6: floor slider stops on its own stop value; then held while done.
        setcfg(16'h0040, 16'h0040, 16'h0090, 16'h0080, 16'h0040, 16'hF000, 1, 2, 10);
        cyc(1'b1, 1'b1, "R8 load");
        run(12, 0, "R6 slider stop");

        // R9: upward wrap past 0xFFFF counts as crossing.
        setcfg(16'hFFF0, 0, 16'hFFFF, 16'hFFFF, 0, 16'hFFFF, 8, 100, 1);
        cyc(1'b1, 1'b1, "R8 load");
        run(5, 0, "R9 wrap up");
        // R9: downward step below 0 counts as crossing.
        setcfg(16'h0004, 0, 0, 16'h0000, 0, 0, 16'hFFFE, 100, 1);
        cyc(1'b1, 1'b1, "R8 load");
        run(6, 0, "R9 wrap down");

        // R8: reload in the middle of a scan.
        setcfg(16'h0300, 16'h0004, 16'h0400, 16'h0320, 16'h0004, 16'h0500, 2, 6, 5);
        cyc(1'b1, 1'b1, "R8 load");
        run(4, 0, "R8 first scan");
        setcfg(16'h0700, 16'h0010, 16'h0800, 16'h0708, 16'h0010, 16'h0900, 1, 20, 2);
        cyc(1'b1, 1'b1, "R8 reload");
        run(25, 1, "R8 second scan");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule